// File: doc/BRIEF.md
# Attribute Controller Flip-Flop Port

This block is the host-facing register port of a display attribute controller. A single write address carries both the register index and the register data. An internal toggle decides which of the two the next write is. A strobe from a read of a separate input status address returns the toggle to index state. This gives software a known starting point before each index/data pair.

The port holds sixteen 6-bit palette mapping entries and five control registers: mode, overscan color, plane enable, horizontal pel panning and color select. Bit 5 of each index byte is kept as a display-enable / palette-lock bit. While it is set, the video output passes the palette-mapped color and host writes to the palette are refused. While it is clear, the video output shows the overscan color. A separate data read strobe returns the register selected by the last latched index and does not move the toggle. The reset values are the text-mode settings.

Top module: `attr_port`

## Requirements
- R1: After reset the toggle is in index state (`flip_o`=0), `video_en_o`=0, `rd_data_o`=0, mode=0x0C, overscan=0x00, plane enable=0xF, pel panning=0x0, color select=0x0, and palette entry i holds the value i.
- R2: A `stat_rd_i` strobe forces the toggle into index state at the next edge. A write in the same cycle is handled as an index write.
- R3: A write in index state latches bits 4:0 of `wr_data_i` as the index and bit 5 as `video_en_o`, and moves the toggle to data state. A write in data state stores data and returns the toggle to index state, with `video_en_o` unchanged.
- R4: A data write with index 0x00 to 0x0F stores `wr_data_i[5:0]` into that palette entry only while `video_en_o`=0. While `video_en_o`=1 the write is ignored.
- R5: Data writes to index 0x10 (mode, 8 bits), 0x11 (overscan, 8 bits), 0x12 (plane enable, bits 3:0), 0x13 (pel panning, bits 3:0) and 0x14 (color select, bits 3:0) update the matching output. Read-back zero-fills the unused upper bits.
- R6: Data writes to indexes 0x15 to 0x1F change no register. Reads of those indexes return 0x00.
- R7: A `data_rd_i` strobe loads `rd_data_o` at the next edge with the register selected by the index latched before that edge, and leaves the toggle unchanged. Without a strobe `rd_data_o` holds its value.
- R8: `pix_o` is combinational. It equals {2'b00, palette[`pix_idx_i`]} when `video_en_o`=1, and the overscan register otherwise.
- R9: `flip_o` shows the toggle: 1 means the next write is taken as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe on the shared index/data address |
| wr_data_i | input | 8 | Write data byte |
| stat_rd_i | input | 1 | Read strobe of the input status address |
| data_rd_i | input | 1 | Read strobe of the data read-back address |
| rd_data_o | output | 8 | Read-back data, registered |
| flip_o | output | 1 | Toggle state, 1 = data expected next |
| video_en_o | output | 1 | Display enable / palette lock bit |
| pix_idx_i | input | 4 | Pixel attribute index into the palette |
| pix_o | output | 8 | Video color output |
| mode_o | output | 8 | Mode register |
| overscan_o | output | 8 | Overscan color register |
| plane_en_o | output | 4 | Plane enable register |
| pel_pan_o | output | 4 | Horizontal pel panning register |
| color_sel_o | output | 4 | Color select register |

## Verification
Directed sequences come first. They cover a clean index/data pair, and a palette write with the lock bit clear and then with it set, which shows whether bit 5 really gates palette writes. They also cover an undefined index, whose write and read must both leave no trace, and a status read in the same cycle as a write, which shows whether the status read wins over the toggle. Random traffic follows. It mixes writes, status reads and data reads in every combination, often with data reads in the same cycle as a write, which shows whether read-back uses the index from before the edge. A model of the registers is compared against all outputs after every cycle.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int DW    = 8;
  localparam int IDX_W = 5;
  localparam int PAL_N = 16;
  localparam int PAL_W = 6;
  localparam int CTL_W = 4;

  localparam logic [IDX_W-1:0] IX_MODE  = 5'h10;
  localparam logic [IDX_W-1:0] IX_OVSC  = 5'h11;
  localparam logic [IDX_W-1:0] IX_PLANE = 5'h12;
  localparam logic [IDX_W-1:0] IX_PAN   = 5'h13;
  localparam logic [IDX_W-1:0] IX_CSEL  = 5'h14;

  localparam logic [DW-1:0]    RST_MODE  = 8'h0C;
  localparam logic [DW-1:0]    RST_OVSC  = 8'h00;
  localparam logic [CTL_W-1:0] RST_PLANE = 4'hF;
  localparam logic [CTL_W-1:0] RST_PAN   = 4'h0;
  localparam logic [CTL_W-1:0] RST_CSEL  = 4'h0;

  localparam int VEN_BIT = 5;

  typedef enum logic {ST_INDEX = 1'b0, ST_DATA = 1'b1} flip_e;
endpackage

// File: rtl/attr_flip_ctrl.sv
module attr_flip_ctrl
  import attr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             stat_rd_i,
  output flip_e            flip_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             video_en_o,
  output logic             data_we_o
);
  flip_e state_q, state_eff;

  // status read takes effect before a concurrent write
  assign state_eff = stat_rd_i ? ST_INDEX : state_q;
  assign data_we_o = wr_en_i && (state_eff == ST_DATA);
  assign flip_o    = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_INDEX;
      idx_o      <= '0;
      video_en_o <= 1'b0;
    end else if (wr_en_i) begin
      if (state_eff == ST_INDEX) begin
        idx_o      <= wr_data_i[IDX_W-1:0];
        video_en_o <= wr_data_i[VEN_BIT];
        state_q    <= ST_DATA;
      end else begin
        state_q    <= ST_INDEX;
      end
    end else if (stat_rd_i) begin
      state_q <= ST_INDEX;
    end
  end

  AST_STAT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && !wr_en_i |=> flip_o == ST_INDEX); // R2
  AST_STAT_WR_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && wr_en_i |=> flip_o == ST_DATA); // R2
  AST_IDX_TO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !stat_rd_i && flip_o == ST_INDEX |=> flip_o == ST_DATA); // R3
  AST_DATA_TO_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !stat_rd_i && flip_o == ST_DATA |=> flip_o == ST_INDEX); // R3
  AST_DATA_KEEPS_VEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_o |=> $stable(video_en_o) && $stable(idx_o)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && !stat_rd_i |=> $stable(flip_o)); // R7
endmodule

// File: rtl/attr_reg_file.sv
module attr_reg_file
  import attr_pkg::*;
#(
  parameter int N_PAL = PAL_N,
  parameter int W_PAL = PAL_W,
  localparam int PSEL_W = $clog2(N_PAL)
)(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              pal_lock_i,
  input  logic              rd_en_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic [PSEL_W-1:0] pix_idx_i,
  output logic [W_PAL-1:0]  pal_pix_o,
  output logic [DW-1:0]     mode_o,
  output logic [DW-1:0]     overscan_o,
  output logic [CTL_W-1:0]  plane_en_o,
  output logic [CTL_W-1:0]  pel_pan_o,
  output logic [CTL_W-1:0]  color_sel_o
);
  logic [W_PAL-1:0]       pal_q [N_PAL];
  logic [N_PAL*W_PAL-1:0] pal_flat;
  logic                   is_pal;
  logic                   is_undef;
  logic [DW-1:0]          rd_mux;

  assign is_pal   = (32'(idx_i) < N_PAL);
  assign is_undef = (idx_i > IX_CSEL);

  for (genvar i = 0; i < N_PAL; i++) begin : g_pal
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        pal_q[i] <= W_PAL'(i);
      else if (we_i && !pal_lock_i && 32'(idx_i) == i)
        pal_q[i] <= wdata_i[W_PAL-1:0];
    end
    assign pal_flat[i*W_PAL +: W_PAL] = pal_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o      <= RST_MODE;
      overscan_o  <= RST_OVSC;
      plane_en_o  <= RST_PLANE;
      pel_pan_o   <= RST_PAN;
      color_sel_o <= RST_CSEL;
    end else if (we_i) begin
      unique case (idx_i)
        IX_MODE:  mode_o      <= wdata_i;
        IX_OVSC:  overscan_o  <= wdata_i;
        IX_PLANE: plane_en_o  <= wdata_i[CTL_W-1:0];
        IX_PAN:   pel_pan_o   <= wdata_i[CTL_W-1:0];
        IX_CSEL:  color_sel_o <= wdata_i[CTL_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    if (is_pal) begin
      rd_mux = DW'(pal_q[idx_i[PSEL_W-1:0]]);
    end else begin
      unique case (idx_i)
        IX_MODE:  rd_mux = mode_o;
        IX_OVSC:  rd_mux = overscan_o;
        IX_PLANE: rd_mux = DW'(plane_en_o);
        IX_PAN:   rd_mux = DW'(pel_pan_o);
        IX_CSEL:  rd_mux = DW'(color_sel_o);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_mux;
  end

  assign pal_pix_o = pal_q[pix_idx_i];

  AST_PAL_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && pal_lock_i |=> $stable(pal_flat)); // R4
  AST_UNDEF_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && is_undef |=> $stable({pal_flat, mode_o, overscan_o, plane_en_o, pel_pan_o, color_sel_o})); // R6
  AST_UNDEF_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && is_undef |=> rd_data_o == '0); // R6
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o)); // R7
  AST_CTL_ONLY_ON_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable({mode_o, overscan_o, plane_en_o, pel_pan_o, color_sel_o})); // R5
endmodule

// File: rtl/attr_pix_mux.sv
module attr_pix_mux
  import attr_pkg::*;
#(
  parameter int W_PAL = PAL_W
)(
  input  logic             video_en_i,
  input  logic [W_PAL-1:0] pal_val_i,
  input  logic [DW-1:0]    overscan_i,
  output logic [DW-1:0]    pix_o
);
  always_comb begin
    if (video_en_i) pix_o = DW'(pal_val_i);
    else            pix_o = overscan_i;
  end

  always_comb begin
    if (video_en_i) AST_PIX_HI_ZERO: assert (pix_o[DW-1:W_PAL] == '0); // R8
  end
endmodule

// File: rtl/attr_port.sv
module attr_port
  import attr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [7:0]  wr_data_i,
  input  logic        stat_rd_i,
  input  logic        data_rd_i,
  output logic [7:0]  rd_data_o,
  output logic        flip_o,
  output logic        video_en_o,
  input  logic [3:0]  pix_idx_i,
  output logic [7:0]  pix_o,
  output logic [7:0]  mode_o,
  output logic [7:0]  overscan_o,
  output logic [3:0]  plane_en_o,
  output logic [3:0]  pel_pan_o,
  output logic [3:0]  color_sel_o
);
  flip_e            flip_st;
  logic [IDX_W-1:0] idx_q;
  logic             data_we;
  logic [PAL_W-1:0] pal_val;

  attr_flip_ctrl u_flip (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .stat_rd_i  (stat_rd_i),
    .flip_o     (flip_st),
    .idx_o      (idx_q),
    .video_en_o (video_en_o),
    .data_we_o  (data_we)
  );

  attr_reg_file #(.N_PAL(PAL_N), .W_PAL(PAL_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (data_we),
    .idx_i       (idx_q),
    .wdata_i     (wr_data_i),
    .pal_lock_i  (video_en_o),
    .rd_en_i     (data_rd_i),
    .rd_data_o   (rd_data_o),
    .pix_idx_i   (pix_idx_i),
    .pal_pix_o   (pal_val),
    .mode_o      (mode_o),
    .overscan_o  (overscan_o),
    .plane_en_o  (plane_en_o),
    .pel_pan_o   (pel_pan_o),
    .color_sel_o (color_sel_o)
  );

  attr_pix_mux #(.W_PAL(PAL_W)) u_pix (
    .video_en_i (video_en_o),
    .pal_val_i  (pal_val),
    .overscan_i (overscan_o),
    .pix_o      (pix_o)
  );

  assign flip_o = (flip_st == ST_DATA);

  AST_RD_KEEPS_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd_i && !wr_en_i && !stat_rd_i |=> $stable(flip_o)); // R7
  AST_VEN_FROM_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (stat_rd_i || !flip_o) |=> video_en_o == $past(wr_data_i[VEN_BIT])); // R3
endmodule

// File: tb/sim_attr_port.sv
`timescale 1ns/1ps
module sim_attr_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, stat_rd = 1'b0, data_rd = 1'b0;
  logic [7:0] wr_data = '0;
  logic [3:0] pix_idx = '0;
  logic [7:0] rd_data, pix, mode, ovsc;
  logic       flip, ven;
  logic [3:0] plane, pan, csel;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // model
  bit         m_flip, m_ven;
  logic [4:0] m_idx;
  logic [5:0] m_pal [16];
  logic [7:0] m_mode, m_ovsc, m_rd;
  logic [3:0] m_plane, m_pan, m_csel;

  always #2.5 clk = ~clk;

  attr_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .stat_rd_i(stat_rd), .data_rd_i(data_rd), .rd_data_o(rd_data),
    .flip_o(flip), .video_en_o(ven), .pix_idx_i(pix_idx), .pix_o(pix),
    .mode_o(mode), .overscan_o(ovsc), .plane_en_o(plane),
    .pel_pan_o(pan), .color_sel_o(csel)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [4:0] ix);
    if (ix < 5'h10) return {2'b00, m_pal[ix[3:0]]};
    case (ix)
      5'h10: return m_mode;
      5'h11: return m_ovsc;
      5'h12: return {4'h0, m_plane};
      5'h13: return {4'h0, m_pan};
      5'h14: return {4'h0, m_csel};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_pix(logic [3:0] p);
    return m_ven ? {2'b00, m_pal[p]} : m_ovsc;
  endfunction

  task automatic model_reset();
    m_flip = 0; m_ven = 0; m_idx = '0; m_rd = '0;
    m_mode = 8'h0C; m_ovsc = 8'h00; m_plane = 4'hF; m_pan = 4'h0; m_csel = 4'h0;
    for (int i = 0; i < 16; i++) m_pal[i] = 6'(i);
  endtask

  task automatic check_all();
    chk("R9 flip", {7'b0, flip}, {7'b0, m_flip});
    chk("R3 video_en", {7'b0, ven}, {7'b0, m_ven});
    chk("R7 rd_data", rd_data, m_rd);
    chk("R5 mode", mode, m_mode);
    chk("R5 overscan", ovsc, m_ovsc);
    chk("R5 plane", {4'h0, plane}, {4'h0, m_plane});
    chk("R5 pan", {4'h0, pan}, {4'h0, m_pan});
    chk("R5 csel", {4'h0, csel}, {4'h0, m_csel});
    chk("R8 pix", pix, exp_pix(pix_idx));
  endtask

  task automatic step(bit w, logic [7:0] d, bit st, bit rd, logic [3:0] p);
    bit eff;
    @(negedge clk);
    wr_en = w; wr_data = d; stat_rd = st; data_rd = rd; pix_idx = p;
    @(posedge clk);
    if (rd) m_rd = exp_rd(m_idx);
    eff = st ? 1'b0 : m_flip;
    if (w) begin
      if (!eff) begin
        m_idx = d[4:0]; m_ven = d[5]; m_flip = 1;
      end else begin
        m_flip = 0;
        if (m_idx < 5'h10) begin
          if (!m_ven) m_pal[m_idx[3:0]] = d[5:0];
        end else case (m_idx)
          5'h10: m_mode = d;
          5'h11: m_ovsc = d;
          5'h12: m_plane = d[3:0];
          5'h13: m_pan = d[3:0];
          5'h14: m_csel = d[3:0];
          default: ;
        endcase
      end
    end else if (st) m_flip = 0;
    #1;
    wr_en = 0; stat_rd = 0; data_rd = 0;
    check_all();
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    model_reset();
    #12 rst_n = 1'b1;
    // R1 reset state, all palette entries through read-back
    @(negedge clk); #0.5;
    check_all();
    for (int i = 0; i < 21; i++) begin
      step(1, 8'(i), 0, 0, 4'(i));
      step(0, 8'h00, 0, 1, 4'(i));
      chk("R1 reset value", rd_data, (i < 16) ? 8'(i) : exp_rd(5'(i)));
      step(0, 8'h00, 1, 0, 4'(i));
    end
    // R4 palette write unlocked
    step(1, 8'h03, 0, 0, 4'd3);
    step(1, 8'hFF, 0, 0, 4'd3);
    step(0, 8'h00, 0, 1, 4'd3);
    chk("R4 pal write", rd_data, 8'h3F);
    // R4 palette write locked, R8 palette on pix
    step(1, 8'h23, 0, 0, 4'd3);
    step(1, 8'h11, 0, 0, 4'd3);
    step(0, 8'h00, 0, 1, 4'd3);
    chk("R4 pal locked", rd_data, 8'h3F);
    chk("R8 pix enabled", pix, 8'h3F);
    // R6 undefined index
    step(1, 8'h15, 0, 0, 4'd0);
    step(1, 8'hAA, 0, 0, 4'd0);
    step(0, 8'h00, 0, 1, 4'd0);
    chk("R6 undef read", rd_data, 8'h00);
    chk("R6 undef no write", mode, 8'h0C);
    // R2 status read with write in data state -> taken as index
    step(1, 8'h11, 0, 0, 4'd0);
    step(1, 8'h12, 1, 0, 4'd0);
    chk("R2 stat+wr index", {7'b0, flip}, 8'h01);
    step(1, 8'hF5, 0, 0, 4'd0);
    chk("R5 plane write", {4'h0, plane}, 8'h05);
    chk("R8 pix overscan", pix, 8'h00);
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      d = 8'($urandom);
      if ($urandom_range(0, 3) == 0) d[4] = 1'b0;
      if ($urandom_range(0, 2) == 0) d[5] = 1'b0;
      step($urandom_range(0, 1) == 1, d, $urandom_range(0, 5) == 0,
           $urandom_range(0, 2) == 0, 4'($urandom));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule